// File: doc/BRIEF.md
# Prefix Generate/Propagate Adder

This block adds two unsigned WIDTH-bit operands and a carry-in, producing a WIDTH-bit sum and a carry-out. It does not chain full-adder cells. It works in three stages. Each operand bit first yields a generate/propagate pair. A prefix network then merges these pairs into group pairs, each spanning from its bit down to position zero. The last stage XORs each bit's propagate with the group generate just below it.

The carry-in gets a prefix position of its own, below bit 0. At that position the generate is the carry-in and the propagate is zero. As a result, every group that reaches position zero already includes the carry-in, and the carry-out is simply the top group generate.

Parameters choose the network and its cells. The network is either a serial chain, whose depth grows linearly with WIDTH, or a log-depth tree. Tree cells can merge two or four sub-groups at once. The carry path can use the OR form of propagate in place of the XOR form. The block is purely combinational.

Top module: `pg_prefix_adder`

## Requirements
- R1: Each sum bit i equals a_i XOR b_i XOR the carry into bit i, where the carry into bit 0 is cin_i.
- R2: The carry-in acts as prefix position zero: with both operands zero, sum_o equals cin_i in bit 0 and zero elsewhere, and cout_o is 0.
- R3: cout_o equals bit WIDTH of the full-width sum a_i + b_i + cin_i (for example, all-ones plus zero plus carry-in gives a zero sum with cout_o = 1).
- R4: When a_i XOR b_i is all ones, the carry passes through every bit: cout_o equals cin_i, and sum_o is all ones when cin_i = 0 and all zeros when cin_i = 1.
- R5: A bit whose two operand bits are both 0 absorbs any incoming carry, so the carry out of that bit is 0.
- R6: With the serial network selected, {cout_o, sum_o} equals a_i + b_i + cin_i for every input combination.
- R7: With the tree network selected and two-input combine cells, {cout_o, sum_o} equals a_i + b_i + cin_i for every input combination.
- R8: With the tree network selected and four-input combine cells, {cout_o, sum_o} equals a_i + b_i + cin_i for every input combination.
- R9: When the OR form of propagate is selected for the carry path, the results are still exact, because the sum stage keeps using the XOR form.
- R10: The outputs follow the inputs with no clock edge in between; the block has no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in, injected as prefix position zero |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry-out, the group generate over all positions |

## Verification
The assertions assume the operands and the carry-in carry only known 0/1 values. While any input bit is unknown they are skipped, since a combinational adder has nothing meaningful to report on undefined operands. The bench drives every input to a defined value from time zero. It changes the inputs only at falling clock edges, so each check sees settled values and never an intermediate state.

// File: rtl/pgadd_pkg.sv
package pgadd_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    typedef enum logic {
        NET_SERIAL = 1'b0,
        NET_TREE   = 1'b1
    } net_kind_e;

    // Merge a higher group with the adjacent lower group.
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/pgadd_bitpg.sv
module pgadd_bitpg
    import pgadd_pkg::*;
#(
    parameter int WIDTH         = 8,
    parameter bit CARRY_OR_PROP = 1'b0,
    localparam int M            = WIDTH + 1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output gp_t              pg_o [M],
    output logic [WIDTH-1:0] px_o
);
    // Position zero holds the carry-in; it never propagates.
    assign pg_o[0] = '{g: cin_i, p: 1'b0};
    assign px_o    = a_i ^ b_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (CARRY_OR_PROP) begin : g_or
            assign pg_o[i+1] = '{g: a_i[i] & b_i[i], p: a_i[i] | b_i[i]};
        end else begin : g_xor
            assign pg_o[i+1] = '{g: a_i[i] & b_i[i], p: a_i[i] ^ b_i[i]};
        end
    end
endmodule

// File: rtl/pgadd_serial_net.sv
module pgadd_serial_net
    import pgadd_pkg::*;
#(
    parameter int M = 9
) (
    input  gp_t gp_i  [M],
    output gp_t grp_o [M]
);
    // Chain of generate-only cells: each group reaches position zero.
    for (genvar i = 0; i < M; i++) begin : g_pos
        gp_t node_d;
        if (i == 0) begin : g_base
            assign node_d = gp_i[0];
        end else begin : g_gray
            assign node_d = '{g: gp_i[i].g | (gp_i[i].p & g_pos[i-1].node_d.g),
                              p: 1'b0};
        end
        assign grp_o[i] = node_d;
    end
endmodule

// File: rtl/pgadd_tree_net.sv
module pgadd_tree_net
    import pgadd_pkg::*;
#(
    parameter int M     = 9,
    parameter int RADIX = 2,
    localparam int LOG_R  = $clog2(RADIX),
    localparam int LEVELS = ($clog2(M) + LOG_R - 1) / LOG_R
) (
    input  gp_t gp_i  [M],
    output gp_t grp_o [M]
);
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int D = RADIX ** l;
        gp_t src_d [M];
        gp_t dst_d [M];

        if (l == 0) begin : g_first
            assign src_d = gp_i;
        end else begin : g_next
            assign src_d = g_lvl[l-1].dst_d;
        end

        for (genvar i = 0; i < M; i++) begin : g_pos
            if (i < D) begin : g_buf
                // Group already reaches position zero: pass through.
                assign dst_d[i] = src_d[i];
            end else begin : g_cell
                for (genvar k = 0; k < RADIX; k++) begin : g_k
                    gp_t acc_d;
                    if (k == 0) begin : g_seed
                        assign acc_d = src_d[i];
                    end else if (i >= k * D) begin : g_merge
                        assign acc_d = gp_merge(g_k[k-1].acc_d, src_d[i-k*D]);
                    end else begin : g_hold
                        assign acc_d = g_k[k-1].acc_d;
                    end
                end
                assign dst_d[i] = g_k[RADIX-1].acc_d;
            end
        end
    end

    assign grp_o = g_lvl[LEVELS-1].dst_d;
endmodule

// File: rtl/pgadd_sum.sv
module pgadd_sum #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] px_i,
    input  logic [WIDTH:0]   carry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    assign sum_o  = px_i ^ carry_i[WIDTH-1:0];
    assign cout_o = carry_i[WIDTH];
endmodule

// File: rtl/pg_prefix_adder.sv
module pg_prefix_adder
    import pgadd_pkg::*;
#(
    parameter int        WIDTH         = 8,
    parameter net_kind_e NETWORK       = NET_TREE,
    parameter int        RADIX         = 2,
    parameter bit        CARRY_OR_PROP = 1'b0
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int M = WIDTH + 1;

    gp_t              pg_d  [M];
    gp_t              grp_d [M];
    logic [WIDTH-1:0] px_d;
    logic [WIDTH:0]   carry_d;
    logic [M-1:0]     grp_p_unused;

    pgadd_bitpg #(
        .WIDTH        (WIDTH),
        .CARRY_OR_PROP(CARRY_OR_PROP)
    ) u_bitpg (
        .a_i  (a_i),
        .b_i  (b_i),
        .cin_i(cin_i),
        .pg_o (pg_d),
        .px_o (px_d)
    );

    if (NETWORK == NET_SERIAL) begin : g_serial
        pgadd_serial_net #(.M(M)) u_net (
            .gp_i (pg_d),
            .grp_o(grp_d)
        );
    end else begin : g_tree
        pgadd_tree_net #(.M(M), .RADIX(RADIX)) u_net (
            .gp_i (pg_d),
            .grp_o(grp_d)
        );
    end

    // Group generate at position k is the carry into operand bit k.
    for (genvar k = 0; k < M; k++) begin : g_carry
        assign carry_d[k]      = grp_d[k].g;
        assign grp_p_unused[k] = grp_d[k].p;
    end

    pgadd_sum #(.WIDTH(WIDTH)) u_sum (
        .px_i   (px_d),
        .carry_i(carry_d),
        .sum_o  (sum_o),
        .cout_o (cout_o)
    );
endmodule

// File: rtl/pgadd_checker.sv
module pgadd_checker #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic [WIDTH:0]   carry_i
);
    logic [WIDTH:0] total_d;
    assign total_d = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            assert_sum_bits_R1: assert (sum_o == (a_i ^ b_i ^ carry_i[WIDTH-1:0]))
                else $error("sum bits disagree with carries");
            assert_cin_seed_R2: assert (carry_i[0] == cin_i)
                else $error("carry into bit 0 is not the carry-in");
            assert_total_R3: assert ({cout_o, sum_o} == total_d)
                else $error("result differs from arithmetic sum");
            if ((a_i ^ b_i) == {WIDTH{1'b1}}) begin
                assert_relay_R4: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}})
                    else $error("full propagate chain broken");
            end
            for (int i = 0; i < WIDTH; i++) begin
                if (!a_i[i] && !b_i[i]) begin
                    assert_kill_R5: assert (!carry_i[i+1])
                        else $error("carry leaked through a killing bit");
                end
            end
        end
    end
endmodule

bind pg_prefix_adder pgadd_checker #(.WIDTH(WIDTH)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o),
    .carry_i(carry_d)
);

// File: tb/pg_prefix_adder_tb.sv
module pg_prefix_adder_tb;
    import pgadd_pkg::*;

    localparam int NW = 8;
    localparam int WW = 32;

    typedef struct {
        logic [NW:0] exp_n;
        logic [WW:0] exp_w;
        bit          wide;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NW-1:0] a8 = '0, b8 = '0;
    logic          c8 = 1'b0;
    logic [WW-1:0] a32 = '0, b32 = '0;
    logic          c32 = 1'b0;

    logic [NW-1:0] sum_t, sum_s, sum_q;
    logic          cout_t, cout_s, cout_q;
    logic [WW-1:0] sum_w;
    logic          cout_w;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;
    item_t sb_q[$];

    pg_prefix_adder #(.WIDTH(NW), .NETWORK(NET_TREE), .RADIX(2)) u_dut (
        .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(sum_t), .cout_o(cout_t));
    pg_prefix_adder #(.WIDTH(NW), .NETWORK(NET_SERIAL)) u_dut_ser (
        .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(sum_s), .cout_o(cout_s));
    pg_prefix_adder #(.WIDTH(NW), .NETWORK(NET_TREE), .RADIX(4)) u_dut_r4 (
        .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(sum_q), .cout_o(cout_q));
    pg_prefix_adder #(.WIDTH(WW), .NETWORK(NET_TREE), .RADIX(4),
                      .CARRY_OR_PROP(1'b1)) u_dut_wide (
        .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(sum_w), .cout_o(cout_w));

    task automatic check(input string tag, input logic [WW:0] got, input logic [WW:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver: apply a narrow vector and push its expected result.
    task automatic drive_n(input logic [NW-1:0] a, input logic [NW-1:0] b,
                           input logic c, input string tag);
        item_t it;
        @(negedge clk);
        a8 = a; b8 = b; c8 = c;
        it.exp_n = {1'b0, a} + {1'b0, b} + {{NW{1'b0}}, c};
        it.exp_w = '0;
        it.wide  = 1'b0;
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    task automatic drive_w(input logic [WW-1:0] a, input logic [WW-1:0] b,
                           input logic c, input string tag);
        item_t it;
        @(negedge clk);
        a32 = a; b32 = b; c32 = c;
        it.exp_n = '0;
        it.exp_w = {1'b0, a} + {1'b0, b} + {{WW{1'b0}}, c};
        it.wide  = 1'b1;
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: at the rising edge, half a cycle after the inputs moved.
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            if (it.wide) begin
                check({it.tag, " R9 wide or-prop"}, {cout_w, sum_w}, it.exp_w);
            end else begin
                check({it.tag, " R7 tree2"},  {{(WW-NW){1'b0}}, cout_t, sum_t}, {{(WW-NW){1'b0}}, it.exp_n});
                check({it.tag, " R6 serial"}, {{(WW-NW){1'b0}}, cout_s, sum_s}, {{(WW-NW){1'b0}}, it.exp_n});
                check({it.tag, " R8 tree4"},  {{(WW-NW){1'b0}}, cout_q, sum_q}, {{(WW-NW){1'b0}}, it.exp_n});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below 190000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // Inputs all zero: outputs zero (R2 with cin = 0).
        #1;
        check("reset-state R2", {{(WW-NW){1'b0}}, cout_t, sum_t}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        drive_n(8'h00, 8'h00, 1'b1, "cin alone R2");
        drive_n(8'hFF, 8'h00, 1'b1, "carry out R3");
        drive_n(8'h80, 8'h80, 1'b0, "top generate R3");
        drive_n(8'hA5, 8'h5A, 1'b1, "propagate all R4");
        drive_n(8'hA5, 8'h5A, 1'b0, "propagate all R4");
        drive_n(8'h0F, 8'h01, 1'b1, "kill at bit 4 R5");
        drive_n(8'h6F, 8'h01, 1'b0, "kill at bit 7 R5");
        drive_n(8'h3C, 8'h66, 1'b1, "sum bits R1");

        // Combinational: outputs valid before any clock edge (R10).
        @(negedge clk);
        a8 = 8'h7E; b8 = 8'h03; c8 = 1'b1;
        #1;
        check("no clock R10", {{(WW-NW){1'b0}}, cout_t, sum_t}, 33'h082);
        a8 = 8'hFF; b8 = 8'h01; c8 = 1'b0;
        #1;
        check("no clock R10", {{(WW-NW){1'b0}}, cout_t, sum_t}, 33'h100);
        a8 = 8'h00; b8 = 8'h00; c8 = 1'b0;

        // Exhaustive narrow sweep (R6, R7, R8).
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < 2; c++) begin
                    drive_n(a[7:0], b[7:0], c[0], "sweep");
                end
            end
        end

        // Wide instance: corners then random (R9, also R3/R4).
        drive_w(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "wide carry out R3");
        drive_w(32'hAAAA_5555, 32'h5555_AAAA, 1'b1, "wide propagate R4");
        drive_w(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "wide all ones");
        for (int n = 0; n < 3000; n++) begin
            drive_w($urandom, $urandom, 1'($urandom), "wide random");
        end

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule